// File: doc/BRIEF.md
# Ignition Wake Deglitch Controller

This block turns the two comparator outputs of an ignition-style wake pin into a clean sleep/awake decision. One comparator reports that the pin sits above the upper threshold, the other that it sits below the lower threshold. A move to awake is accepted only when the upper comparator stays asserted for a full on-interval. A move back to sleep is accepted only when the lower comparator stays asserted for a full off-interval. Any break in the qualifying level before the interval ends throws the event away, and the next attempt starts timing again from zero.

Both comparator outputs are asynchronous to the block clock and pass through a synchronizer first. The on and off intervals are counted in clock cycles. While awake, a second timer counts the pulses of a free-running tick input and emits a one-cycle keep-alive pulse each time a full period of ticks has elapsed. With a 250 MHz clock and a 1 ms tick, the defaults give 10 µs filters and a 200 ms keep-alive period.

Top module: `iwk_wake_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `awake` is 0 and `keepalive` is 0.
- R2: From sleep, if `above_hi` is held high for ON_CYCLES clock samples in a row, `awake` rises. With the input changing just after clock edge 0, `awake` is still 0 after edge ON_CYCLES+SYNC_STAGES-1 and is 1 after edge ON_CYCLES+SYNC_STAGES.
- R3: From sleep, a high pulse on `above_hi` that lasts ON_CYCLES-1 samples leaves `awake` at 0.
- R4: From awake, if `below_lo` is held high for OFF_CYCLES samples in a row, `awake` falls, with the same latency rule as R2 using OFF_CYCLES.
- R5: From awake, a high pulse on `below_lo` that lasts OFF_CYCLES-1 samples leaves `awake` at 1.
- R6: A sample in which the relevant comparator is low (including the band between the thresholds, where both are low) keeps the current state and restarts the running interval. Two qualifying runs of length one short of the limit, separated by one such sample, cause no transition.
- R7: `below_lo` has no effect while asleep, and `above_hi` has no effect while awake.
- R8: While awake, `keepalive` is high for exactly one cycle each time KA_TICKS tick cycles have been counted since waking or since the previous pulse. It appears one edge after the clock edge that samples the closing tick.
- R9: `keepalive` never pulses while asleep. The tick count is cleared whenever the block is asleep, so each wake starts a fresh period.
- R10: The on and off filters count clock cycles whether or not `tick` is high. With `tick` held low, no keep-alive pulse occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Free-running time-base strobe, one cycle wide |
| above_hi | input | 1 | Asynchronous comparator: pin above upper threshold |
| below_lo | input | 1 | Asynchronous comparator: pin below lower threshold |
| awake | output | 1 | Registered wake state, 1 = awake |
| keepalive | output | 1 | Registered one-cycle keep-alive pulse |

## Verification
The hardest case is a qualifying run that is exactly one sample too short, followed immediately by another such run. This case separates a timer that restarts from one that merely pauses. Seen from the ports, it is hidden behind the synchronizer delay. The bench drives each comparator for a counted number of clock edges right after an edge, so the number of synchronized samples is known exactly. It then chains two runs of length limit-minus-one with a single in-band sample between them, and compares them with a run of exactly the limit length.

// File: rtl/iwk_pkg.sv
package iwk_pkg;
  typedef enum logic {
    ST_SLEEP = 1'b0,
    ST_AWAKE = 1'b1
  } wake_st_e;

  // width for a counter that must hold values 0..limit-1 (at least 1 bit)
  function automatic int cnt_width(input int limit);
    return (limit <= 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/iwk_sync.sv
module iwk_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d_async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/iwk_deglitch.sv
module iwk_deglitch #(
  parameter int LIMIT = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic cond,
  output logic fire
);
  localparam int CW = iwk_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign run  = arm && cond;
  assign fire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (!run || fire)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // counter never passes the last accepted value
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // a nonzero count means the previous sample qualified; otherwise it restarted
  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> $past(arm && cond));
endmodule

// File: rtl/iwk_keepalive.sv
module iwk_keepalive #(
  parameter int PERIOD = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic pulse
);
  localparam int CW = iwk_pkg::cnt_width(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (cnt == LAST) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_ka_gap_R8: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  assert_ka_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/iwk_wake_ctrl.sv
module iwk_wake_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int ON_CYCLES   = 2500,
  parameter int OFF_CYCLES  = 2500,
  parameter int KA_TICKS    = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic above_hi,
  input  logic below_lo,
  output logic awake,
  output logic keepalive
);
  import iwk_pkg::*;

  localparam int NCMP = 2;

  logic [NCMP-1:0] cmp_s;
  logic            hi_s, lo_s;
  logic            on_fire, off_fire;
  wake_st_e        st;

  iwk_sync #(.WIDTH(NCMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({below_lo, above_hi}),
    .q_sync  (cmp_s)
  );

  assign hi_s = cmp_s[0];
  assign lo_s = cmp_s[1];

  iwk_deglitch #(.LIMIT(ON_CYCLES)) u_on_flt (
    .clk  (clk),
    .rst  (rst),
    .arm  (st == ST_SLEEP),
    .cond (hi_s),
    .fire (on_fire)
  );

  iwk_deglitch #(.LIMIT(OFF_CYCLES)) u_off_flt (
    .clk  (clk),
    .rst  (rst),
    .arm  (st == ST_AWAKE),
    .cond (lo_s),
    .fire (off_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) st <= ST_SLEEP;
    else begin
      case (st)
        ST_SLEEP: if (on_fire)  st <= ST_AWAKE;
        ST_AWAKE: if (off_fire) st <= ST_SLEEP;
        default:                st <= ST_SLEEP;
      endcase
    end
  end

  assign awake = (st == ST_AWAKE);

  iwk_keepalive #(.PERIOD(KA_TICKS)) u_ka (
    .clk   (clk),
    .rst   (rst),
    .run   (awake),
    .tick  (tick),
    .pulse (keepalive)
  );

  initial begin
    assert_params_R2: assert (ON_CYCLES >= 1 && OFF_CYCLES >= 1 && KA_TICKS >= 2 && SYNC_STAGES >= 1);
  end

  assert_wake_src_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(awake) |-> $past(hi_s));

  assert_sleep_src_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(awake) |-> $past(lo_s));

  assert_ka_awake_R9: assert property (@(posedge clk) disable iff (rst)
    keepalive |-> $past(awake));
endmodule

// File: tb/iwk_wake_ctrl_bench.sv
module iwk_wake_ctrl_bench;
  localparam int SYNC = 2;
  localparam int ON   = 6;
  localparam int OFF  = 4;
  localparam int KA   = 3;

  logic clk = 0, rst = 1, tick = 0, above_hi = 0, below_lo = 0;
  logic awake, keepalive;
  logic tick_en = 1;
  int   div = 0;
  int   checks = 0, fails = 0;

  int  m_cnt = 0;
  bit  exp_p = 0;
  int  obs_pulses = 0;
  int  exp_pulses = 0;

  always #2 clk = ~clk;

  iwk_wake_ctrl #(.SYNC_STAGES(SYNC), .ON_CYCLES(ON), .OFF_CYCLES(OFF), .KA_TICKS(KA)) u_iwk_wake_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .above_hi(above_hi), .below_lo(below_lo),
    .awake(awake), .keepalive(keepalive)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b @%0t", tag, act, exp, $time);
    end
  endtask

  // tick generator: one cycle high out of three when enabled
  initial forever begin
    @(posedge clk); #1;
    tick = tick_en && (div == 0);
    div  = (div == 2) ? 0 : div + 1;
  end

  // keep-alive reference model (R8, R9, R10)
  always @(negedge clk) begin
    if (rst) begin
      m_cnt = 0; exp_p = 0;
    end else begin
      if (keepalive) obs_pulses++;
      if (exp_p) exp_pulses++;
      if (exp_p || keepalive) chk("R8 keepalive timing", keepalive, exp_p);
      exp_p = 0;
      if (!awake) m_cnt = 0;
      else if (tick) begin
        m_cnt++;
        if (m_cnt == KA) begin m_cnt = 0; exp_p = 1; end
      end
    end
  end

  task automatic drive(input logic h, input logic l);
    @(posedge clk); #1;
    above_hi = h; below_lo = l;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // hold a level for exactly n samples, then return to the middle band
  task automatic hold(input logic h, input logic l, input int n);
    drive(h, l);
    repeat (n - 1) @(posedge clk);
    drive(0, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 awake in reset", awake, 0);
    chk("R1 keepalive in reset", keepalive, 0);
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk("R1 awake after reset", awake, 0);
    chk("R1 keepalive after reset", keepalive, 0);
  endtask

  task automatic t_short_on;
    hold(1, 0, ON - 1);
    cycles(ON + 4);
    chk("R3 short high pulse", awake, 0);
    hold(1, 0, ON - 1);
    hold(1, 0, ON - 1);
    cycles(ON + 4);
    chk("R6 split high runs", awake, 0);
  endtask

  task automatic t_sleep_ignores_lo;
    hold(0, 1, 3 * OFF);
    cycles(4);
    chk("R7 below_lo while asleep", awake, 0);
  endtask

  task automatic t_wake_latency;
    drive(1, 0);
    repeat (ON + SYNC - 1) @(posedge clk);
    @(negedge clk);
    chk("R2 not yet awake", awake, 0);
    @(posedge clk); @(negedge clk);
    chk("R2 awake at latency", awake, 1);
    drive(0, 0);
  endtask

  task automatic t_awake_ignores_hi;
    hold(1, 0, 3 * ON);
    cycles(4);
    chk("R7 above_hi while awake", awake, 1);
  endtask

  task automatic t_short_off;
    hold(0, 1, OFF - 1);
    cycles(OFF + 4);
    chk("R5 short low pulse", awake, 1);
    hold(0, 1, OFF - 1);
    hold(0, 1, OFF - 1);
    cycles(OFF + 4);
    chk("R6 split low runs", awake, 1);
  endtask

  task automatic t_keepalive_window;
    int p0, e0;
    p0 = obs_pulses; e0 = exp_pulses;
    cycles(10 * KA * 3);
    chk("R8 pulses seen while awake", (obs_pulses - p0) > 0, 1);
    chk("R8 pulse count matches", (obs_pulses - p0) == (exp_pulses - e0), 1);
  endtask

  task automatic t_sleep_latency;
    drive(0, 1);
    repeat (OFF + SYNC - 1) @(posedge clk);
    @(negedge clk);
    chk("R4 still awake", awake, 1);
    @(posedge clk); @(negedge clk);
    chk("R4 asleep at latency", awake, 0);
    drive(0, 0);
  endtask

  task automatic t_no_pulse_asleep;
    int p0;
    p0 = obs_pulses;
    cycles(10 * KA * 3);
    chk("R9 no pulse while asleep", obs_pulses == p0, 1);
  endtask

  task automatic t_exact_on;
    hold(1, 0, ON);
    cycles(4);
    chk("R2 exact-length run wakes", awake, 1);
  endtask

  task automatic t_no_tick;
    int p0;
    tick_en = 0;
    hold(0, 1, OFF);
    cycles(4);
    chk("R10 sleep without tick", awake, 0);
    hold(1, 0, ON);
    cycles(4);
    chk("R10 wake without tick", awake, 1);
    p0 = obs_pulses;
    cycles(40);
    chk("R10 no pulse without tick", obs_pulses == p0, 1);
    tick_en = 1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_short_on();
    t_sleep_ignores_lo();
    t_wake_latency();
    t_awake_ignores_hi();
    t_short_off();
    t_keepalive_window();
    t_sleep_latency();
    t_no_pulse_asleep();
    t_exact_on();
    t_keepalive_window();
    t_no_tick();
    t_keepalive_window();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule